// File: doc/BRIEF.md
# Triangle Ramp Code Generator

This block produces an 8-bit parallel code for an external DAC that traces a symmetric triangle. A single packed control word sets the step added to the code on every pacing tick (which fixes the peak height) and the number of ticks in each half of the wave (which, with the tick rate, fixes the frequency). The code climbs by the step for that many ticks, falls by the same step for the same number of ticks, and then repeats.

A one-cycle start pulse captures the control word, clears the code to zero and begins a fresh rising half. The control word is not looked at on any other cycle. Before capturing, the block checks that the peak (step times half-period count) fits in the code width and that the half-period count is not zero. When either check fails it raises an error flag and holds the code at zero until the next start.

Top module: `tri_ramp_gen`

## Requirements
- R1: After reset `dac_code` is 0 and `param_error` is 0, and the code stays 0 under ticks until the first start pulse.
- R2: On a cycle with `start` high, `ctrl_word` is captured; on the next cycle `dac_code` is 0 and a new rising half begins, whatever state the ramp was in before. `start` takes priority over `tick` on the same cycle.
- R3: The step is `ctrl_word[15:8]` and the half-period count is `ctrl_word[23:16]`; during the rising half each of `period` ticks adds the step, so after k ticks (1 ≤ k ≤ period) the code is k × step and the peak is step × period.
- R4: During the falling half each of the next `period` ticks subtracts the step, so after 2 × period ticks the code is 0 again, and the pattern repeats with period 2 × period ticks.
- R5: `dac_code` is registered and changes only on cycles where `tick` is high; a cycle with `tick` low and no start leaves it unchanged.
- R6: If step × period ≥ 256, `param_error` is 1 from the cycle after the start and `dac_code` stays 0 regardless of ticks, until the next start.
- R7: A half-period count of 0 is illegal: it sets `param_error` and holds the code at 0 like R6. A legal word clears `param_error` on its start.
- R8: Changes on `ctrl_word` while `start` is low have no effect, and bits 7:0 of `ctrl_word` (a channel tag) never affect the code or the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture `ctrl_word` and restart the wave at 0 |
| ctrl_word | input | 24 | Packed word: [23:16] half-period count, [15:8] step, [7:0] channel tag |
| tick | input | 1 | Sample strobe; one step per high cycle |
| dac_code | output | 8 | Parallel code for the DAC |
| param_error | output | 1 | Captured word was illegal; code held at 0 |

## Verification
The assertions assume that `start` and `tick` are clean single-bit levels sampled on the rising edge and that a start on the same cycle as a tick is a restart, not a step; they assume nothing about the spacing of ticks. The stimulus keeps to this by driving all inputs on the falling edge, sweeps step and half-period pairs both inside and outside the legal region, inserts idle cycles between ticks, and changes the control word between start pulses so that the ignore rule is exercised without breaking the assumptions. Expected codes come from the closed-form position within the 2 × period cycle.

// File: rtl/tri_ramp_gen.sv
module tri_ramp_gen #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [3*W-1:0] ctrl_word,
  input  logic           tick,
  output logic [W-1:0]   dac_code,
  output logic           param_error
);

  localparam int CW = 3*W;

  logic [W-1:0]   step_in, per_in;
  logic [2*W-1:0] prod_in;
  logic           bad_in;

  assign step_in = ctrl_word[2*W-1:W];
  assign per_in  = ctrl_word[CW-1:2*W];
  assign prod_in = {{W{1'b0}}, step_in} * {{W{1'b0}}, per_in};
  assign bad_in  = (per_in == '0) || (prod_in[2*W-1:W] != '0);

  logic [W-1:0] step_q, per_q, cnt_q;
  logic         falling_q, active_q;
  logic         last_tick;

  assign last_tick = (cnt_q == per_q - W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q      <= '0;
      per_q       <= '0;
      cnt_q       <= '0;
      falling_q   <= 1'b0;
      active_q    <= 1'b0;
      param_error <= 1'b0;
      dac_code    <= '0;
    end else if (start) begin
      step_q      <= step_in;
      per_q       <= per_in;
      cnt_q       <= '0;
      falling_q   <= 1'b0;
      active_q    <= !bad_in;
      param_error <= bad_in;
      dac_code    <= '0;
    end else if (tick && active_q) begin
      dac_code  <= falling_q ? dac_code - step_q : dac_code + step_q;
      cnt_q     <= last_tick ? '0 : cnt_q + W'(1);
      falling_q <= last_tick ? !falling_q : falling_q;
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && !param_error) |-> dac_code == '0);

  p_start_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> dac_code == '0);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> ({{W{1'b0}}, dac_code} <= {{W{1'b0}}, step_q} * {{W{1'b0}}, per_q}));

  p_hold_no_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !start) |=> $stable(dac_code));

  p_err_holds_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    param_error |-> dac_code == '0);

  p_err_only_on_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(param_error));

  p_word_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(step_q) && $stable(per_q)));

endmodule

// File: tb/tb_tri_ramp_gen.sv
module tb_tri_ramp_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] ctrl_word = '0;
  logic        tick = 1'b0;
  logic [7:0]  dac_code;
  logic        param_error;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  tri_ramp_gen dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ctrl_word(ctrl_word),
    .tick(tick), .dac_code(dac_code), .param_error(param_error)
  );

  always #5 clk = ~clk;

  function automatic int exp_code(int step, int per, int n);
    int p;
    p = n % (2*per);
    return (p <= per) ? p*step : (2*per - p)*step;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_start(int step, int per, int tag);
    @(negedge clk);
    ctrl_word = {8'(per), 8'(step), 8'(tag)};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic do_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic run_wave(int step, int per, int tag, bit gaps);
    int base;
    do_start(step, per, tag);
    check("R2 code after start", int'(dac_code), 0);
    check("R7 flag clear for legal word", int'(param_error), 0);
    for (int n = 1; n <= 4*per + 1; n++) begin
      if (n == 2) ctrl_word = {8'(per + 3), 8'(step ^ 8'h5a), 8'(tag + 1)};
      do_tick();
      base = exp_code(step, per, n);
      if (n <= per) check("R3 rising code", int'(dac_code), base);
      else          check("R4 falling/repeat code (R8 word ignored)", int'(dac_code), base);
      if (gaps && (n % 3 == 0)) begin
        @(negedge clk);
        check("R5 no change without tick", int'(dac_code), base);
      end
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int steps[8] = '{0, 1, 2, 3, 5, 17, 85, 255};
    int pers[8]  = '{1, 2, 3, 4, 7, 15, 127, 255};
    repeat (3) @(negedge clk);
    check("R1 reset code", int'(dac_code), 0);
    check("R1 reset flag", int'(param_error), 0);
    rst_n = 1'b1;
    @(negedge clk);
    ctrl_word = {8'd4, 8'd3, 8'd0};
    for (int i = 0; i < 5; i++) begin
      do_tick();
      check("R1 idle before first start", int'(dac_code), 0);
    end

    foreach (steps[i]) foreach (pers[j]) begin
      if (steps[i] * pers[j] < 256) run_wave(steps[i], pers[j], i*8 + j, (i + j) % 2 == 1);
    end

    run_wave(21, 12, 8'hff, 1'b1);

    do_start(4, 6, 0);
    repeat (8) do_tick();
    check("R4 mid-wave value", int'(dac_code), exp_code(4, 6, 8));
    @(negedge clk);
    ctrl_word = {8'd5, 8'd7, 8'd9};
    start = 1'b1;
    tick = 1'b1;
    @(negedge clk);
    start = 1'b0;
    tick = 1'b0;
    check("R2 restart beats tick", int'(dac_code), 0);
    for (int n = 1; n <= 10; n++) begin
      do_tick();
      check("R2 fresh cycle after restart", int'(dac_code), exp_code(7, 5, n));
    end

    for (int s = 0; s < 256; s += 3) begin
      for (int p = 0; p < 256; p++) begin
        do_start(s, p, (s + p) & 255);
        check((p == 0) ? "R7 zero period flag" : "R6 product rule flag",
              int'(param_error), ((p == 0) || (s*p >= 256)) ? 1 : 0);
      end
    end

    do_start(16, 16, 0);
    check("R6 flag on 256 product", int'(param_error), 1);
    for (int n = 0; n < 6; n++) begin
      do_tick();
      check("R6 code held at 0", int'(dac_code), 0);
    end
    do_start(3, 0, 0);
    check("R7 zero period flag", int'(param_error), 1);
    do_tick();
    check("R7 code held at 0", int'(dac_code), 0);
    do_start(15, 17, 0);
    check("R7 legal word clears flag", int'(param_error), 0);
    do_tick();
    check("R3 first step after clear", int'(dac_code), 15);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule